// File: doc/BRIEF.md
# Host-side I2C bit-bang port

This block is a byte-wide peripheral that lives in a sixteen-offset host I/O window. Software uses it to drive a two-wire serial EEPROM one edge at a time. A single write-only mode flag chooses what the window shows. In one view, accesses pass through to a network controller's register file, and this block holds that controller's bank-select register. In the other view, the window becomes a small set of line-control strobes.

In the EEPROM view, touching one of four strobe offsets forces the clock line or the data line low or releases it high. Either a read or a write counts as a touch. A fifth offset returns the data line as seen through a two-flop synchroniser. Both lines are open-drain: an enable output pulls the line low, and a released line is left to an external pull-up. Protocol sequencing and bit timing are done entirely in software.

Top module: `i2c_bitbang_port`

## Requirements
- R1: After reset the window is in controller view, the bank select is 0, and both line pull-downs are enabled (`scl_oe`=1, `sda_oe`=1).
- R2: A write to offset 0xF sets the view from data bit 0 (1 = EEPROM view, 0 = controller view). The write is decoded in both views.
- R3: In EEPROM view, any access to offset 0x4 enables the clock pull-down and any access to offset 0x5 releases it. The change is visible after the clock edge that takes the access, and these offsets read 0x00.
- R4: In EEPROM view, any access to offset 0x6 enables the data pull-down and any access to offset 0x7 releases it. The change is visible after the clock edge, and these offsets read 0x00.
- R5: In EEPROM view, a read of offset 0x8 returns the data pin in bit 0 and zeros in bits 7..1. The pin passes through two flops, so a pin change first shows on a read issued two cycles later.
- R6: In EEPROM view, offsets other than 0x4–0x8 and 0xF read 0x00. Writes to them change neither line nor the bank select, and no access is forwarded (`ctl_sel`=0).
- R7: In controller view, accesses to offsets 0x0–0xD assert `ctl_sel` and return `ctl_rdata`. Accesses to the strobe offsets have no effect on the lines.
- R8: In controller view, a write to offset 0xE loads the bank select from data bits 2..0, and a read of 0xE returns it zero-extended. The bank select appears on `ctl_bank`, is not written from EEPROM view, and survives view switches.
- R9: A read of offset 0xF returns 0x00 in either view.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| ctl_sel | output | 1 | Access forwarded to the network controller |
| ctl_rdata | input | 8 | Read data from the network controller |
| ctl_bank | output | 3 | Controller bank select |
| sda_in | input | 1 | Sampled data pin |
| scl_oe | output | 1 | Clock line pull-down enable |
| sda_oe | output | 1 | Data line pull-down enable |

## Verification
Two things can happen in the same cycle: the data pin can change while a status read of offset 0x8 is under way. The bench lowers the pin on the same falling edge on which it starts a read of 0x8. It then repeats the read in each of the next two cycles. The first two reads must still return the old level and the third must return the new one, which confirms the two-cycle synchroniser latency rather than a combinational path.

// File: rtl/i2c_bitbang_port.sv
module i2c_bitbang_port #(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int BANK_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          ctl_sel,
  input  logic [DW-1:0] ctl_rdata,
  output logic [BANK_W-1:0] ctl_bank,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam logic [AW-1:0] OFS_SCL_LO = AW'(4);
  localparam logic [AW-1:0] OFS_SCL_HI = AW'(5);
  localparam logic [AW-1:0] OFS_SDA_LO = AW'(6);
  localparam logic [AW-1:0] OFS_SDA_HI = AW'(7);
  localparam logic [AW-1:0] OFS_SDA_RD = AW'(8);
  localparam logic [AW-1:0] OFS_BANK   = AW'(14);
  localparam logic [AW-1:0] OFS_MODE   = AW'(15);

  logic              eep_mode;
  logic [BANK_W-1:0] bank_q;
  logic              scl_lo, sda_lo;
  logic [1:0]        sda_sync;

  wire own_ofs  = (bus_addr == OFS_MODE) || (bus_addr == OFS_BANK);
  wire eep_acc  = bus_sel && eep_mode;
  wire mode_wr  = bus_sel && bus_wr && (bus_addr == OFS_MODE);
  wire bank_wr  = bus_sel && bus_wr && !eep_mode && (bus_addr == OFS_BANK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eep_mode <= 1'b0;
      bank_q   <= '0;
      scl_lo   <= 1'b1;
      sda_lo   <= 1'b1;
      sda_sync <= '0;
    end else begin
      sda_sync <= {sda_sync[0], sda_in};
      if (mode_wr) eep_mode <= bus_wdata[0];
      if (bank_wr) bank_q <= bus_wdata[BANK_W-1:0];
      if (eep_acc) begin
        case (bus_addr)
          OFS_SCL_LO: scl_lo <= 1'b1;
          OFS_SCL_HI: scl_lo <= 1'b0;
          OFS_SDA_LO: sda_lo <= 1'b1;
          OFS_SDA_HI: sda_lo <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_MODE)
      bus_rdata = '0;
    else if (eep_mode) begin
      if (bus_addr == OFS_SDA_RD) bus_rdata[0] = sda_sync[1];
    end else if (bus_addr == OFS_BANK)
      bus_rdata[BANK_W-1:0] = bank_q;
    else
      bus_rdata = ctl_rdata;
  end

  assign ctl_sel  = bus_sel && !eep_mode && !own_ofs;
  assign ctl_bank = bank_q;
  assign scl_oe   = scl_lo;
  assign sda_oe   = sda_lo;
endmodule

module i2c_bitbang_port_chk #(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int BANK_W = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic          ctl_sel,
  input logic [BANK_W-1:0] ctl_bank,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          eep_mode
);
  AST_CLK_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && eep_mode && bus_addr == AW'(4)) |=> scl_oe); // R3
  AST_CLK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && eep_mode && bus_addr == AW'(5)) |=> !scl_oe); // R3
  AST_DAT_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && eep_mode && bus_addr == AW'(6)) |=> sda_oe); // R4
  AST_DAT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && eep_mode && bus_addr == AW'(7)) |=> !sda_oe); // R4
  AST_STAT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && eep_mode && bus_addr == AW'(8)) |-> bus_rdata[DW-1:1] == '0); // R5
  AST_NO_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    eep_mode |-> !ctl_sel); // R6
  AST_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel || !eep_mode) |=> ($stable(scl_oe) && $stable(sda_oe))); // R7
  AST_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && eep_mode) |=> $stable(ctl_bank)); // R8
  AST_MODE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == AW'(15)) |-> bus_rdata == '0); // R9
endmodule

bind i2c_bitbang_port i2c_bitbang_port_chk #(.AW(AW), .DW(DW), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .ctl_sel(ctl_sel), .ctl_bank(ctl_bank),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .eep_mode(eep_mode)
);

// File: tb/test_i2c_bitbang_port.sv
module test_i2c_bitbang_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic ctl_sel;
  logic [7:0] ctl_rdata = 8'hA5;
  logic [2:0] ctl_bank;
  logic pin_sda = 1'b1;
  logic scl_oe, sda_oe;

  int total = 0, bad = 0;
  logic [7:0] rd_now;
  logic fwd_now;

  always #5 clk = ~clk;

  i2c_bitbang_port i_i2c_bitbang_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctl_sel(ctl_sel), .ctl_rdata(ctl_rdata), .ctl_bank(ctl_bank),
    .sda_in(pin_sda), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // vector: [27] wr, [26:23] addr, [22:15] wdata, [14:7] exp rdata (reads only),
  //         [6] exp scl_oe, [5] exp sda_oe, [4:0] requirement number
  localparam int NV = 23;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 4'hF, 8'h01, 8'h00, 1'b1, 1'b1, 5'd2}, // R2 enter EEPROM view
    {1'b1, 4'h5, 8'h00, 8'h00, 1'b0, 1'b1, 5'd3}, // R3 release clock
    {1'b0, 4'h4, 8'h00, 8'h00, 1'b1, 1'b1, 5'd3}, // R3 read strobe pulls clock
    {1'b0, 4'h7, 8'h00, 8'h00, 1'b1, 1'b0, 5'd4}, // R4 read strobe releases data
    {1'b1, 4'h6, 8'h00, 8'h00, 1'b1, 1'b1, 5'd4}, // R4 pull data
    {1'b0, 4'h8, 8'h00, 8'h01, 1'b1, 1'b1, 5'd5}, // R5 pin high
    {1'b1, 4'h2, 8'hFF, 8'h00, 1'b1, 1'b1, 5'd6}, // R6 ignored write
    {1'b0, 4'h2, 8'h00, 8'h00, 1'b1, 1'b1, 5'd6}, // R6 reads zero
    {1'b1, 4'h5, 8'h00, 8'h00, 1'b0, 1'b1, 5'd3}, // R3
    {1'b1, 4'h7, 8'h00, 8'h00, 1'b0, 1'b0, 5'd4}, // R4
    {1'b0, 4'hF, 8'h00, 8'h00, 1'b0, 1'b0, 5'd9}, // R9
    {1'b1, 4'hE, 8'h07, 8'h00, 1'b0, 1'b0, 5'd8}, // R8 bank write ignored here
    {1'b1, 4'hF, 8'h00, 8'h00, 1'b0, 1'b0, 5'd2}, // R2 back to controller view
    {1'b1, 4'h4, 8'h00, 8'h00, 1'b0, 1'b0, 5'd7}, // R7 strobe offset inert
    {1'b0, 4'h6, 8'h00, 8'hA5, 1'b0, 1'b0, 5'd7}, // R7 forwarded read
    {1'b0, 4'hE, 8'h00, 8'h00, 1'b0, 1'b0, 5'd8}, // R8 bank still 0
    {1'b1, 4'hE, 8'h0D, 8'h00, 1'b0, 1'b0, 5'd8}, // R8 bank <= 5
    {1'b0, 4'hE, 8'h00, 8'h05, 1'b0, 1'b0, 5'd8}, // R8
    {1'b1, 4'hF, 8'hFF, 8'h00, 1'b0, 1'b0, 5'd2}, // R2 only bit 0 matters
    {1'b1, 4'h4, 8'h00, 8'h00, 1'b1, 1'b0, 5'd3}, // R3
    {1'b1, 4'hF, 8'h00, 8'h00, 1'b1, 1'b0, 5'd2}, // R2 exit from EEPROM view
    {1'b0, 4'hE, 8'h00, 8'h05, 1'b1, 1'b0, 5'd8}, // R8 bank survived
    {1'b0, 4'hF, 8'h00, 8'h00, 1'b1, 1'b0, 5'd9}  // R9
  };

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // starts at a falling edge, ends at the next falling edge
  task automatic acc(input logic wr, input logic [3:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    rd_now  = bus_rdata;
    fwd_now = ctl_sel;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=00 expected=01");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(scl_oe === 1'b1, "R1 scl_oe", {7'b0, scl_oe}, 8'h01);
    check(sda_oe === 1'b1, "R1 sda_oe", {7'b0, sda_oe}, 8'h01);
    check(ctl_bank === 3'd0, "R1 bank", {5'b0, ctl_bank}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    acc(1'b0, 4'h3, 8'h00);
    check(fwd_now === 1'b1, "R1 controller view at reset", {7'b0, fwd_now}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[4:0], i);
      acc(v[27], v[26:23], v[22:15]);
      if (!v[27]) check(rd_now === v[14:7], {tag, " rdata"}, rd_now, v[14:7]);
      check(scl_oe === v[6], {tag, " scl_oe"}, {7'b0, scl_oe}, {7'b0, v[6]});
      check(sda_oe === v[5], {tag, " sda_oe"}, {7'b0, sda_oe}, {7'b0, v[5]});
    end
    check(ctl_bank === 3'd5, "R8 ctl_bank port", {5'b0, ctl_bank}, 8'h05);

    // R7 forwarding in controller view, R6 none in EEPROM view
    acc(1'b1, 4'hD, 8'h11);
    check(fwd_now === 1'b1, "R7 ctl_sel", {7'b0, fwd_now}, 8'h01);
    acc(1'b1, 4'hF, 8'h01);
    acc(1'b1, 4'h3, 8'h11);
    check(fwd_now === 1'b0, "R6 ctl_sel", {7'b0, fwd_now}, 8'h00);

    // R5 pin change in the same cycle as a status read
    acc(1'b0, 4'h8, 8'h00);
    check(rd_now === 8'h01, "R5 pin high", rd_now, 8'h01);
    pin_sda = 1'b0;
    acc(1'b0, 4'h8, 8'h00);
    check(rd_now === 8'h01, "R5 same cycle", rd_now, 8'h01);
    acc(1'b0, 4'h8, 8'h00);
    check(rd_now === 8'h01, "R5 one stage", rd_now, 8'h01);
    acc(1'b0, 4'h8, 8'h00);
    check(rd_now === 8'h00, "R5 two stages", rd_now, 8'h00);

    // R1 reset mid-run restores defaults
    acc(1'b1, 4'h5, 8'h00);
    acc(1'b1, 4'h7, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(scl_oe === 1'b1 && sda_oe === 1'b1, "R1 lines after reset", {6'b0, scl_oe, sda_oe}, 8'h03);
    check(ctl_bank === 3'd0, "R1 bank after reset", {5'b0, ctl_bank}, 8'h00);
    acc(1'b0, 4'h6, 8'h00);
    check(rd_now === 8'hA5, "R1 view after reset", rd_now, 8'hA5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule